// File: doc/BRIEF.md
# EEPROM Page-Write Sequencer

This block drives one complete write transaction to a small serial EEPROM from the master side. It does not shift bits itself. It sits on top of a byte-level SPI transfer engine and drives that engine's start, transmit-byte, receive-byte and completion signals. It also owns the device's active-low chip select. A request carries a 9-bit start address and a byte count. The data bytes arrive on a separate valid/ready stream and are pulled one at a time as the transaction needs them.

Before it touches the bus, the sequencer checks the request. A request is refused with no bus activity if it has a count of zero, or if its bytes would run past the end of a 16-byte page. An accepted request is carried out as three kinds of chip-select window:

1. A write-enable window.
2. A write window: the command, the low address byte, then the data.
3. A series of status-poll windows, spaced a fixed number of clock cycles apart, until the device reports ready or sixteen polls have all shown busy.

A single-cycle done pulse then reports pass or fail.

Back-pressure rules apply to both streams:

- **Request stream.** A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the sequencer is idle.
- **Data stream.** A data byte is taken on a cycle where `dat_valid` and `dat_ready` are both high. Once `dat_valid` is raised, it and `dat_byte` must hold until that handshake. While the sequencer waits for a data byte, it keeps chip select low and the SPI engine idle.

Top module: `eeprom_page_writer`

## Requirements
- R1: A request with count 0 is refused. The cycle after acceptance shows done=1, fail=1, pass=0. Chip select stays high and no transfer starts.
- R2: A request is refused in the same way when (address bits [3:0] + count) is greater than 16. A sum of exactly 16 is accepted.
- R3: An accepted request first sends byte 0x06 alone in its own select window. A second window then sends 0x02 with address bit 8 placed in bit 3, then address bits [7:0], then the data bytes in stream order.
- R4: Chip select is active low. It goes low one cycle before the first transfer start of a window. It returns high for at least one cycle after the last byte of a window. `xfer_start` is only ever high while chip select is low, and chip select is high in the done cycle.
- R5: Each status poll is its own select window. It sends 0x05, then 0xFF. The byte received during the 0xFF transfer is the status.
- R6: After the write window's deselect cycle, and after each busy poll's deselect cycle, chip select stays high for exactly POLL_CYCLES cycles before the next poll's select cycle.
- R7: A poll whose status has bit 0 equal to 0 ends the transaction with pass in the cycle after that poll's deselect cycle. The other status bits have no effect.
- R8: If 16 polls all show bit 0 equal to 1, the transaction ends with fail after the 16th poll, and no 17th poll is made.
- R9: `done` is high for exactly one cycle per request. In that cycle exactly one of `pass` and `fail` is high. Both are low whenever `done` is low.
- R10: `req_ready` is high only while idle. A request held valid during a transaction is taken only after that transaction's done cycle.
- R11: `dat_ready` is high only when the next byte to send is a data byte, and stays high until `dat_valid` is seen. Chip select stays low and no transfer starts while waiting.
- R12: During and right after reset, chip select is high, `xfer_start`, `done`, `pass` and `fail` are low, and `req_ready` is high.
- R13: A single-byte write is the same transaction as a page write with count 1.
- R14: `xfer_start` is a one-cycle pulse per byte. The next start is issued only after `xfer_done` has been seen for the previous byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request accepted this cycle if valid |
| req_addr | input | 9 | Start address of the write |
| req_count | input | 5 | Number of data bytes |
| dat_valid | input | 1 | Data byte offered |
| dat_ready | output | 1 | Sequencer wants the next data byte |
| dat_byte | input | 8 | Data byte |
| xfer_start | output | 1 | One-cycle request to the SPI engine to move one byte |
| xfer_tx | output | 8 | Byte to send, valid with xfer_start |
| xfer_rx | input | 8 | Byte received, valid with xfer_done |
| xfer_done | input | 1 | SPI engine finished the byte |
| cs_n | output | 1 | Device chip select, active low |
| done | output | 1 | Transaction finished, one cycle |
| pass | output | 1 | Write completed, with done |
| fail | output | 1 | Request refused or device stayed busy, with done |

## Verification
The bound checker covers the per-cycle properties:

- the transfer start only under chip select, and only as a one-cycle pulse;
- select falling one cycle ahead of a start;
- the single-cycle done pulse with exactly one verdict;
- `req_ready` and `dat_ready` against chip select.

The bench covers what needs a scenario: the byte sequence on the wire, the exact interval between polls, the refusal rules at the page edge, the 16-poll limit, a request held through a busy transaction, and a data stream that stalls. It does this by running a behavioural model of the whole transaction next to the design and comparing every output on every cycle.

// File: rtl/eepw_pkg.sv
package eepw_pkg;

  localparam logic [7:0] OP_WR_ENABLE = 8'h06;
  localparam logic [7:0] OP_WR_DATA   = 8'h02;
  localparam logic [7:0] OP_RD_STATUS = 8'h05;
  localparam logic [7:0] FILL_BYTE    = 8'hFF;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_FETCH,
    ST_SEND,
    ST_WAIT,
    ST_DESEL,
    ST_PAUSE,
    ST_DONE
  } seq_state_e;

  typedef enum logic [1:0] {
    WIN_ENABLE,
    WIN_WRITE,
    WIN_POLL
  } window_e;

endpackage

// File: rtl/eepw_req_check.sv
module eepw_req_check #(
  parameter int PAGE_BYTES = 16,
  parameter int CNT_W      = 5
) (
  input  logic [$clog2(PAGE_BYTES)-1:0] page_ofs,
  input  logic [CNT_W-1:0]              count,
  output logic                          req_ok
);
  localparam int OFS_W = $clog2(PAGE_BYTES);
  localparam int SUM_W = CNT_W + 1;

  logic [SUM_W-1:0] end_pos;

  assign end_pos = SUM_W'(page_ofs) + SUM_W'(count);

  always_comb begin
    req_ok = 1'b1;
    if (count == '0)
      req_ok = 1'b0;
    if (end_pos > SUM_W'(PAGE_BYTES))
      req_ok = 1'b0;
  end

  if (OFS_W < 1) begin : g_bad_page
    initial $error("page size must be at least 2 bytes");
  end

endmodule

// File: rtl/eepw_byte_slot.sv
module eepw_byte_slot
  import eepw_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int IDX_W  = 6
) (
  input  window_e           window,
  input  logic [IDX_W-1:0]  idx,
  input  logic [ADDR_W-1:0] addr,
  output logic [7:0]        slot_byte,
  output logic              slot_is_data
);
  logic page_hi;

  if (ADDR_W > 8) begin : g_hi
    assign page_hi = addr[8];
  end else begin : g_no_hi
    assign page_hi = 1'b0;
  end

  always_comb begin
    slot_byte    = FILL_BYTE;
    slot_is_data = 1'b0;
    unique case (window)
      WIN_ENABLE: slot_byte = OP_WR_ENABLE;
      WIN_WRITE: begin
        if (idx == '0)
          slot_byte = OP_WR_DATA | {4'b0000, page_hi, 3'b000};
        else if (idx == IDX_W'(1))
          slot_byte = addr[7:0];
        else
          slot_is_data = 1'b1;
      end
      WIN_POLL: slot_byte = (idx == '0) ? OP_RD_STATUS : FILL_BYTE;
      default:  slot_byte = FILL_BYTE;
    endcase
  end

endmodule

// File: rtl/eepw_poll_pacer.sv
module eepw_poll_pacer #(
  parameter int POLL_CYCLES = 50000,
  parameter int MAX_POLLS   = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic poll_taken,
  output logic interval_up,
  output logic limit_hit
);
  localparam int TW = $clog2(POLL_CYCLES + 1);
  localparam int PW = $clog2(MAX_POLLS + 1);

  logic [TW-1:0] tick_q;
  logic [PW-1:0] polls_q;

  assign interval_up = run && (tick_q == TW'(POLL_CYCLES - 1));
  assign limit_hit   = (polls_q == PW'(MAX_POLLS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      tick_q <= '0;
    else if (!run)
      tick_q <= '0;
    else if (!interval_up)
      tick_q <= tick_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      polls_q <= '0;
    else if (restart)
      polls_q <= '0;
    else if (poll_taken && !limit_hit)
      polls_q <= polls_q + PW'(1);
  end

endmodule

// File: rtl/eepw_seq_ctrl.sv
module eepw_seq_ctrl
  import eepw_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int CNT_W  = 5,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  req_count,
  input  logic              req_ok,
  input  logic              dat_valid,
  input  logic [7:0]        dat_byte,
  input  logic [7:0]        xfer_rx,
  input  logic              xfer_done,
  input  logic [7:0]        slot_byte,
  input  logic              slot_is_data,
  input  logic              interval_up,
  input  logic              limit_hit,
  output window_e           window,
  output logic [IDX_W-1:0]  slot_idx,
  output logic [ADDR_W-1:0] addr_q,
  output logic              pace_run,
  output logic              pace_restart,
  output logic              poll_taken,
  output logic              req_ready,
  output logic              dat_ready,
  output logic              xfer_start,
  output logic [7:0]        xfer_tx,
  output logic              cs_n,
  output logic              done,
  output logic              pass,
  output logic              fail
);
  seq_state_e       state_q;
  window_e          window_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] last_idx;
  logic [CNT_W-1:0] count_q;
  logic [7:0]       byte_q;
  logic             busy_bit_q;
  logic             ok_q;
  logic             rx_unused;

  assign rx_unused = ^xfer_rx[7:1];

  always_comb begin
    unique case (window_q)
      WIN_ENABLE: last_idx = '0;
      WIN_WRITE:  last_idx = IDX_W'(count_q) + IDX_W'(1);
      default:    last_idx = IDX_W'(1);
    endcase
  end

  assign window       = window_q;
  assign slot_idx     = (state_q == ST_SEL) ? '0 : idx_q + IDX_W'(1);
  assign pace_run     = (state_q == ST_PAUSE);
  assign pace_restart = (state_q == ST_DESEL) && (window_q == WIN_WRITE);
  assign poll_taken   = (state_q == ST_PAUSE) && interval_up;

  assign req_ready  = (state_q == ST_IDLE);
  assign dat_ready  = (state_q == ST_FETCH);
  assign xfer_start = (state_q == ST_SEND);
  assign xfer_tx    = byte_q;
  assign cs_n       = !((state_q == ST_SEL)  || (state_q == ST_FETCH) ||
                        (state_q == ST_SEND) || (state_q == ST_WAIT));
  assign done       = (state_q == ST_DONE);
  assign pass       = done && ok_q;
  assign fail       = done && !ok_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      window_q   <= WIN_ENABLE;
      idx_q      <= '0;
      addr_q     <= '0;
      count_q    <= '0;
      byte_q     <= '0;
      busy_bit_q <= 1'b0;
      ok_q       <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            addr_q  <= req_addr;
            count_q <= req_count;
            if (req_ok) begin
              window_q <= WIN_ENABLE;
              state_q  <= ST_SEL;
            end else begin
              ok_q    <= 1'b0;
              state_q <= ST_DONE;
            end
          end
        end
        ST_SEL: begin
          idx_q   <= '0;
          byte_q  <= slot_byte;
          state_q <= ST_SEND;
        end
        ST_SEND: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (xfer_done) begin
            if (window_q == WIN_POLL)
              busy_bit_q <= xfer_rx[0];
            if (idx_q == last_idx) begin
              state_q <= ST_DESEL;
            end else begin
              idx_q <= idx_q + IDX_W'(1);
              if (slot_is_data) begin
                state_q <= ST_FETCH;
              end else begin
                byte_q  <= slot_byte;
                state_q <= ST_SEND;
              end
            end
          end
        end
        ST_FETCH: begin
          if (dat_valid) begin
            byte_q  <= dat_byte;
            state_q <= ST_SEND;
          end
        end
        ST_DESEL: begin
          unique case (window_q)
            WIN_ENABLE: begin
              window_q <= WIN_WRITE;
              state_q  <= ST_SEL;
            end
            WIN_WRITE: state_q <= ST_PAUSE;
            default: begin
              if (!busy_bit_q) begin
                ok_q    <= 1'b1;
                state_q <= ST_DONE;
              end else if (limit_hit) begin
                ok_q    <= 1'b0;
                state_q <= ST_DONE;
              end else begin
                state_q <= ST_PAUSE;
              end
            end
          endcase
        end
        ST_PAUSE: begin
          if (interval_up) begin
            window_q <= WIN_POLL;
            state_q  <= ST_SEL;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
  import eepw_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int PAGE_BYTES  = 16,
  parameter int POLL_CYCLES = 50000,
  parameter int MAX_POLLS   = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic [ADDR_W-1:0]            req_addr,
  input  logic [$clog2(PAGE_BYTES):0]  req_count,
  input  logic                         dat_valid,
  output logic                         dat_ready,
  input  logic [7:0]                   dat_byte,
  output logic                         xfer_start,
  output logic [7:0]                   xfer_tx,
  input  logic [7:0]                   xfer_rx,
  input  logic                         xfer_done,
  output logic                         cs_n,
  output logic                         done,
  output logic                         pass,
  output logic                         fail
);
  localparam int OFS_W = $clog2(PAGE_BYTES);
  localparam int CNT_W = OFS_W + 1;
  localparam int IDX_W = CNT_W + 1;

  logic              req_ok;
  window_e           window;
  logic [IDX_W-1:0]  slot_idx;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        slot_byte;
  logic              slot_is_data;
  logic              pace_run;
  logic              pace_restart;
  logic              poll_taken;
  logic              interval_up;
  logic              limit_hit;

  eepw_req_check #(
    .PAGE_BYTES (PAGE_BYTES),
    .CNT_W      (CNT_W)
  ) u_check (
    .page_ofs (req_addr[OFS_W-1:0]),
    .count    (req_count),
    .req_ok   (req_ok)
  );

  eepw_byte_slot #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W)
  ) u_slot (
    .window       (window),
    .idx          (slot_idx),
    .addr         (addr_q),
    .slot_byte    (slot_byte),
    .slot_is_data (slot_is_data)
  );

  eepw_poll_pacer #(
    .POLL_CYCLES (POLL_CYCLES),
    .MAX_POLLS   (MAX_POLLS)
  ) u_pacer (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (pace_run),
    .restart     (pace_restart),
    .poll_taken  (poll_taken),
    .interval_up (interval_up),
    .limit_hit   (limit_hit)
  );

  eepw_seq_ctrl #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .IDX_W  (IDX_W)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_addr     (req_addr),
    .req_count    (req_count),
    .req_ok       (req_ok),
    .dat_valid    (dat_valid),
    .dat_byte     (dat_byte),
    .xfer_rx      (xfer_rx),
    .xfer_done    (xfer_done),
    .slot_byte    (slot_byte),
    .slot_is_data (slot_is_data),
    .interval_up  (interval_up),
    .limit_hit    (limit_hit),
    .window       (window),
    .slot_idx     (slot_idx),
    .addr_q       (addr_q),
    .pace_run     (pace_run),
    .pace_restart (pace_restart),
    .poll_taken   (poll_taken),
    .req_ready    (req_ready),
    .dat_ready    (dat_ready),
    .xfer_start   (xfer_start),
    .xfer_tx      (xfer_tx),
    .cs_n         (cs_n),
    .done         (done),
    .pass         (pass),
    .fail         (fail)
  );

endmodule

// File: rtl/eeprom_page_writer_chk.sv
module eeprom_page_writer_chk (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic dat_ready,
  input logic xfer_start,
  input logic cs_n,
  input logic done,
  input logic pass,
  input logic fail
);

  AST_START_UNDER_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> !cs_n); // R4

  AST_SELECT_LEADS_START: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> !xfer_start); // R4

  AST_DONE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cs_n); // R4

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !xfer_start); // R14

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $countones({pass, fail}) == 1); // R9

  AST_NO_STRAY_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> !pass && !fail); // R9

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> !req_ready); // R10

  AST_FETCH_UNDER_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    dat_ready |-> !cs_n && !xfer_start); // R11

endmodule

bind eeprom_page_writer eeprom_page_writer_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .dat_ready  (dat_ready),
  .xfer_start (xfer_start),
  .cs_n       (cs_n),
  .done       (done),
  .pass       (pass),
  .fail       (fail)
);

// File: tb/eeprom_page_writer_bench.sv
`timescale 1ns/1ps
module eeprom_page_writer_bench;
  localparam int PACE = 20;
  localparam int LIMIT = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [8:0] req_addr = '0;
  logic [4:0] req_count = '0;
  logic       dat_valid = 1'b0;
  logic       dat_ready;
  logic [7:0] dat_byte = '0;
  logic       xfer_start;
  logic [7:0] xfer_tx;
  logic [7:0] xfer_rx = '0;
  logic       xfer_done = 1'b0;
  logic       cs_n;
  logic       done;
  logic       pass;
  logic       fail;

  always #5 clk = ~clk;

  eeprom_page_writer #(.POLL_CYCLES(PACE)) u_eeprom_page_writer (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_count(req_count),
    .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_byte(dat_byte),
    .xfer_start(xfer_start), .xfer_tx(xfer_tx),
    .xfer_rx(xfer_rx), .xfer_done(xfer_done),
    .cs_n(cs_n), .done(done), .pass(pass), .fail(fail)
  );

  int total = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // ---------------- emulated SPI byte engine and device ----------------
  int lat_cfg = 0;
  int busy_n = 0;
  int polls_seen = 0;
  logic [7:0] last_tx = 8'h00;

  initial begin
    forever begin
      @(negedge clk);
      if (xfer_start) begin
        logic [7:0] tb;
        tb = xfer_tx;
        @(posedge clk);
        repeat (lat_cfg) @(posedge clk);
        #1;
        if (last_tx == 8'h05 && tb == 8'hFF) begin
          xfer_rx = (polls_seen < busy_n) ? 8'h01 : 8'hFE;
          polls_seen++;
        end else begin
          xfer_rx = 8'h00;
        end
        last_tx = tb;
        xfer_done = 1'b1;
        @(posedge clk);
        #1 xfer_done = 1'b0;
      end
    end
  end

  // ---------------- data stream source ----------------
  logic [7:0] dq[$];
  int gap_cfg = 0;
  int gap_cnt = 0;

  initial begin
    forever begin
      bit hs;
      @(negedge clk);
      hs = dat_valid && dat_ready;
      @(posedge clk);
      #1;
      if (hs) begin
        void'(dq.pop_front());
        dat_valid = 1'b0;
        gap_cnt = 0;
      end
      if (!dat_valid && dq.size() > 0) begin
        if (gap_cnt >= gap_cfg) begin
          dat_valid = 1'b1;
          dat_byte  = dq[0];
        end else begin
          gap_cnt++;
        end
      end
    end
  end

  // ---------------- behavioural reference model ----------------
  logic       e_cs_n = 1'b1, e_start = 1'b0, e_rready = 1'b1, e_dready = 1'b0;
  logic       e_done = 1'b0, e_pass = 1'b0, e_fail = 1'b0;
  logic [7:0] e_tx = '0;
  string      e_tag = "R12";
  bit         model_on = 1'b0;
  logic [7:0] mq[$];

  task automatic cyc(input logic cs, input logic st, input logic rr, input logic dr,
                     input logic dn, input logic ps, input logic fl,
                     input logic [7:0] tx, input string tag);
    e_cs_n = cs; e_start = st; e_rready = rr; e_dready = dr;
    e_done = dn; e_pass = ps; e_fail = fl; e_tx = tx; e_tag = tag;
    @(posedge clk);
  endtask

  task automatic m_byte(input logic [7:0] b, input string tag, output logic [7:0] rx);
    cyc(0, 1, 0, 0, 0, 0, 0, b, tag);
    do cyc(0, 0, 0, 0, 0, 0, 0, 8'h00, "R14"); while (!xfer_done);
    rx = xfer_rx;
  endtask

  task automatic m_data(output logic [7:0] rx);
    logic [7:0] b;
    do cyc(0, 0, 0, 1, 0, 0, 0, 8'h00, "R11"); while (!dat_valid);
    b = mq.pop_front();
    m_byte(b, "R3", rx);
  endtask

  task automatic m_write(input logic [8:0] a, input int n);
    logic [7:0] rx;
    bit ok;
    ok = 0;
    cyc(0, 0, 0, 0, 0, 0, 0, 8'h00, "R4");
    m_byte(8'h06, "R3", rx);
    cyc(1, 0, 0, 0, 0, 0, 0, 8'h00, "R4");
    cyc(0, 0, 0, 0, 0, 0, 0, 8'h00, "R4");
    m_byte(8'h02 | {4'b0, a[8], 3'b0}, "R3", rx);
    m_byte(a[7:0], "R3", rx);
    for (int i = 0; i < n; i++) m_data(rx);
    cyc(1, 0, 0, 0, 0, 0, 0, 8'h00, "R4");
    for (int p = 0; p < LIMIT; p++) begin
      repeat (PACE) cyc(1, 0, 0, 0, 0, 0, 0, 8'h00, "R6");
      cyc(0, 0, 0, 0, 0, 0, 0, 8'h00, "R4");
      m_byte(8'h05, "R5", rx);
      m_byte(8'hFF, "R5", rx);
      cyc(1, 0, 0, 0, 0, 0, 0, 8'h00, "R4");
      if (!rx[0]) begin
        ok = 1;
        break;
      end
    end
    cyc(1, 0, 0, 0, 1, ok, !ok, 8'h00, ok ? "R7" : "R8");
  endtask

  initial begin
    wait (rst_n);
    model_on = 1'b1;
    forever begin
      cyc(1, 0, 1, 0, 0, 0, 0, 8'h00, "R10");
      if (req_valid) begin
        logic [8:0] a;
        int n;
        a = req_addr;
        n = int'(req_count);
        if (n == 0)
          cyc(1, 0, 0, 0, 1, 0, 1, 8'h00, "R1");
        else if (int'(a[3:0]) + n > 16)
          cyc(1, 0, 0, 0, 1, 0, 1, 8'h00, "R2");
        else
          m_write(a, n);
      end
    end
  end

  always @(negedge clk) begin
    if (model_on && rst_n) begin
      chk(cs_n === e_cs_n, e_tag, "cs_n", cs_n, e_cs_n);
      chk(xfer_start === e_start, e_tag, "xfer_start", xfer_start, e_start);
      if (e_start) chk(xfer_tx === e_tx, e_tag, "xfer_tx", xfer_tx, e_tx);
      chk(req_ready === e_rready, e_tag, "req_ready", req_ready, e_rready);
      chk(dat_ready === e_dready, e_tag, "dat_ready", dat_ready, e_dready);
      chk(done === e_done, e_tag, "done", done, e_done);
      chk(pass === e_pass, e_tag, "pass", pass, e_pass);
      chk(fail === e_fail, e_tag, "fail", fail, e_fail);
    end
  end

  // ---------------- scenario driver ----------------
  task automatic setup(input int busy, input int lat, input int gap,
                       input logic [7:0] first, input int n);
    busy_n = busy; polls_seen = 0; lat_cfg = lat; gap_cfg = gap;
    for (int i = 0; i < n; i++) begin
      dq.push_back(first + 8'(i * 3));
      mq.push_back(first + 8'(i * 3));
    end
  endtask

  task automatic issue(input logic [8:0] a, input logic [4:0] n);
    @(posedge clk);
    #1;
    req_valid = 1'b1; req_addr = a; req_count = n;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic result(input bit exp_ok, input string tag);
    @(negedge clk);
    while (!done) @(negedge clk);
    chk(pass === exp_ok, tag, "verdict pass", pass, exp_ok);
    chk(fail === !exp_ok, tag, "verdict fail", fail, !exp_ok);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (3) begin
      @(negedge clk);
      chk(cs_n === 1'b1, "R12", "cs_n in reset", cs_n, 1);
      chk(xfer_start === 1'b0 && done === 1'b0 && pass === 1'b0 && fail === 1'b0,
          "R12", "outputs in reset", {xfer_start, done, pass, fail}, 0);
      chk(req_ready === 1'b1, "R12", "req_ready in reset", req_ready, 1);
    end
    @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: zero count
    setup(0, 0, 0, 8'h10, 0);
    issue(9'h020, 5'd0);
    result(0, "R1");

    // R2: crossing the page edge, exact fit, oversize count
    issue(9'h00E, 5'd3);
    result(0, "R2");
    setup(0, 1, 0, 8'h21, 3);
    issue(9'h00D, 5'd3);
    result(1, "R2");
    issue(9'h000, 5'd17);
    result(0, "R2");

    // R13: single byte in upper half of the array (R3 opcode bit)
    setup(0, 0, 0, 8'hA7, 1);
    issue(9'h105, 5'd1);
    result(1, "R13");

    // R11: full page with stalling data stream and slow engine
    setup(3, 2, 2, 8'h30, 16);
    issue(9'h0F0, 5'd16);
    result(1, "R11");

    // R8: device never ready
    setup(99, 0, 0, 8'h40, 2);
    issue(9'h033, 5'd2);
    result(0, "R8");

    // R7: ready on the last allowed poll
    setup(15, 0, 1, 8'h50, 4);
    issue(9'h1C4, 5'd4);
    result(1, "R7");

    // R10: a request held during a busy transaction waits for idle
    setup(1, 1, 0, 8'h60, 2);
    issue(9'h088, 5'd2);
    fork
      issue(9'h090, 5'd0);
      result(1, "R10");
    join
    result(0, "R10");

    repeat (5) @(negedge clk);
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL R9 watchdog: done not reached, got 0 expected 1");
    summary();
    $finish;
  end

endmodule